// File: doc/BRIEF.md
# BCD Millisecond Counter with Pulse Timing

This block is a three-digit decimal counter that advances by one on every pulse of a 1 kHz tick, so one count equals one millisecond and the full range covers 0 to 999 ms. The tick arrives as a single-cycle pulse from a divider outside the block. The count is kept in BCD, one 4-bit digit per decade.

Counting is enabled in one of several ways, chosen by a mode input. Software strobes can start and stop it. In the two hardware modes the level of an external pin opens the gate, either while the pin is high (pulse width) or between two successive rising edges (period), after which the count freezes for software to read. A software clear zeroes the count.

An interrupt pulse marks a decimal rollover. One select value marks every tenth of a second, when the lower two digits pass from 99 to 00. The other marks every full second, when the whole count passes from 999 to 000.

Top module: `msc_bcd_timer`

## Requirements
- R1: `count_o` holds ms units in bits 3:0, tens in bits 7:4 and hundreds in bits 11:8. Every digit stays within 0..9. After reset the count is 000 and `irq_o` is low.
- R2: A counting tick raises the value by exactly one with a decimal carry between digits, and 999 wraps to 000. The new value shows in the cycle after the tick.
- R3: In a cycle without `tick_i` and without a clear, the count does not change.
- R4: In software mode (`mode_i`=0), a tick counts only while the run flag is set. `sw_start_i` sets the flag and `sw_stop_i` clears it, each from the next cycle. Stop wins when both strobes are high, and the flag is low after reset.
- R5: In any mode other than 0, `sw_start_i` and `sw_stop_i` leave the run flag unchanged.
- R6: In pulse-width mode (`mode_i`=1), a tick counts only in a cycle in which `pin_i` is high.
- R7: Period mode (`mode_i`=2) handles rising edges of `pin_i`, where an edge means pin high in this cycle and low in the previous one (taken as low before the first cycle after reset). Ticks count from the cycle after a first edge up to and including the cycle of the next edge. The count then stays frozen until a clear or until the mode leaves 2, either of which rearms the wait for a first edge.
- R8: In mode 3 no tick counts.
- R9: `sw_clear_i` zeroes the count in the next cycle in every mode. It takes priority over a tick in the same cycle and raises no interrupt.
- R10: With `irq_sel_i`=0, `irq_o` pulses for one cycle, in the same cycle as the new count, after a counting tick that moves the lower two digits from 99 to 00.
- R11: With `irq_sel_i`=1, `irq_o` pulses only after a counting tick that moves the count from 999 to 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 kHz tick, one cycle wide |
| pin_i | input | 1 | External start/stop pin, already synchronous |
| sw_start_i | input | 1 | Software start strobe |
| sw_stop_i | input | 1 | Software stop strobe |
| sw_clear_i | input | 1 | Software clear strobe |
| mode_i | input | 2 | 0 software, 1 pulse width, 2 period, 3 off |
| irq_sel_i | input | 1 | 0 tenth-second rollover, 1 one-second rollover |
| count_o | output | 12 | BCD count, three digits |
| irq_o | output | 1 | Rollover interrupt pulse |

## Verification
On every cycle the assertions check that each digit stays decimal and that the count holds when no tick arrives. They also check that it holds while the pin is low in pulse-width mode and in the off mode, that a clear lands on zero with no interrupt, and that an interrupt only coincides with a count ending in 00. Only the bench's scenarios can show the behaviour that depends on history: the run flag surviving strobes given in other modes, the period gate opening and closing on the right edges and then freezing, stop winning over start, and the tenth-second and one-second rollovers found by counting through hundreds of ticks.

// File: rtl/msc_pkg.sv
package msc_pkg;
  typedef enum logic [1:0] {
    MODE_SW     = 2'd0,
    MODE_WIDTH  = 2'd1,
    MODE_PERIOD = 2'd2,
    MODE_OFF    = 2'd3
  } msc_mode_e;

  typedef enum logic [1:0] {
    PER_ARM  = 2'd0,
    PER_RUN  = 2'd1,
    PER_DONE = 2'd2
  } msc_per_e;
endpackage

// File: rtl/msc_gate.sv
module msc_gate
  import msc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       pin_i,
  input  logic       sw_start_i,
  input  logic       sw_stop_i,
  input  logic       sw_clear_i,
  output logic       run_o
);
  logic     pin_q;
  logic     sw_run_q;
  msc_per_e per_q;
  logic     pin_rise;

  assign pin_rise = pin_i & ~pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_i;
  end

  // strobes only act in software mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_run_q <= 1'b0;
    end else if (mode_i == MODE_SW) begin
      if (sw_stop_i)       sw_run_q <= 1'b0;
      else if (sw_start_i) sw_run_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= PER_ARM;
    end else if (mode_i != MODE_PERIOD || sw_clear_i) begin
      per_q <= PER_ARM;
    end else begin
      unique case (per_q)
        PER_ARM: if (pin_rise) per_q <= PER_RUN;
        PER_RUN: if (pin_rise) per_q <= PER_DONE;
        default: per_q <= PER_DONE;
      endcase
    end
  end

  always_comb begin
    unique case (mode_i)
      MODE_SW:     run_o = sw_run_q;
      MODE_WIDTH:  run_o = pin_i;
      MODE_PERIOD: run_o = (per_q == PER_RUN);
      default:     run_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/msc_bcd_chain.sv
module msc_bcd_chain #(
  parameter int NUM_DIGITS = 3,
  parameter int TENTH_IDX  = 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    adv_i,
  input  logic                    clear_i,
  output logic [4*NUM_DIGITS-1:0] count_o,
  output logic                    tenth_wrap_o,
  output logic                    full_wrap_o
);
  localparam int DIG_W = 4;

  logic [NUM_DIGITS:0] carry;
  assign carry[0] = adv_i;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dig
    logic [DIG_W-1:0] d_q;
    logic             at9;

    assign at9        = (d_q == DIG_W'(9));
    assign carry[g+1] = carry[g] & at9;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       d_q <= '0;
      else if (clear_i)  d_q <= '0;
      else if (carry[g]) d_q <= at9 ? '0 : d_q + DIG_W'(1);
    end

    assign count_o[DIG_W*g +: DIG_W] = d_q;
  end

  assign tenth_wrap_o = carry[TENTH_IDX+1];
  assign full_wrap_o  = carry[NUM_DIGITS];
endmodule

// File: rtl/msc_irq.sv
module msc_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tenth_wrap_i,
  input  logic full_wrap_i,
  input  logic sel_i,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= sel_i ? full_wrap_i : tenth_wrap_i;
  end
endmodule

// File: rtl/msc_bcd_timer.sv
module msc_bcd_timer #(
  parameter int NUM_DIGITS = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic                    pin_i,
  input  logic                    sw_start_i,
  input  logic                    sw_stop_i,
  input  logic                    sw_clear_i,
  input  logic [1:0]              mode_i,
  input  logic                    irq_sel_i,
  output logic [4*NUM_DIGITS-1:0] count_o,
  output logic                    irq_o
);
  localparam int TENTH_IDX = 1; // 1 ms per count: digits 0..1 span 100 ms

  logic run;
  logic adv;
  logic tenth_wrap;
  logic full_wrap;

  msc_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .pin_i      (pin_i),
    .sw_start_i (sw_start_i),
    .sw_stop_i  (sw_stop_i),
    .sw_clear_i (sw_clear_i),
    .run_o      (run)
  );

  // clear beats counting
  assign adv = tick_i & run & ~sw_clear_i;

  msc_bcd_chain #(
    .NUM_DIGITS (NUM_DIGITS),
    .TENTH_IDX  (TENTH_IDX)
  ) u_chain (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .adv_i        (adv),
    .clear_i      (sw_clear_i),
    .count_o      (count_o),
    .tenth_wrap_o (tenth_wrap),
    .full_wrap_o  (full_wrap)
  );

  msc_irq u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tenth_wrap_i (tenth_wrap),
    .full_wrap_i  (full_wrap),
    .sel_i        (irq_sel_i),
    .irq_o        (irq_o)
  );
endmodule

// File: rtl/msc_bcd_timer_chk.sv
module msc_bcd_timer_chk #(
  parameter int NUM_DIGITS = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    tick_i,
  input logic                    pin_i,
  input logic                    sw_clear_i,
  input logic [1:0]              mode_i,
  input logic [4*NUM_DIGITS-1:0] count_o,
  input logic                    irq_o
);
  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dchk
    a_r1_digit_decimal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_o[4*g +: 4] <= 4'd9);
  end

  a_r3_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !sw_clear_i) |=> $stable(count_o));

  a_r6_width_low_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && !pin_i && !sw_clear_i) |=> $stable(count_o));

  a_r8_off_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3 && !sw_clear_i) |=> $stable(count_o));

  a_r9_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_clear_i |=> (count_o == '0) && !irq_o);

  a_r10_irq_on_rollover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (count_o[7:0] == 8'h00));
endmodule

bind msc_bcd_timer msc_bcd_timer_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .pin_i      (pin_i),
  .sw_clear_i (sw_clear_i),
  .mode_i     (mode_i),
  .count_o    (count_o),
  .irq_o      (irq_o)
);

// File: tb/tb_msc_bcd_timer.sv
module tb_msc_bcd_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, pin = 1'b0;
  logic        start = 1'b0, stop = 1'b0, clr = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        sel = 1'b0;
  logic [11:0] count;
  logic        irq;

  int    n_chk = 0, n_bad = 0;
  bit    done = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  msc_bcd_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pin_i(pin),
    .sw_start_i(start), .sw_stop_i(stop), .sw_clear_i(clr),
    .mode_i(mode), .irq_sel_i(sel), .count_o(count), .irq_o(irq)
  );

  // behavioural reference
  int m_cnt, m_pst;
  bit m_irq, m_run, m_pin;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_irq = 0; m_run = 0; m_pst = 0; m_pin = 0;
    end else begin
      bit en, adv, rise;
      case (mode)
        2'd0: en = m_run;
        2'd1: en = pin;
        2'd2: en = (m_pst == 1);
        default: en = 0;
      endcase
      adv   = tick && en && !clr;
      m_irq = adv && (sel ? (m_cnt == 999) : (m_cnt % 100 == 99));
      if (clr) m_cnt = 0;
      else if (adv) m_cnt = (m_cnt + 1) % 1000;
      if (mode == 2'd0) begin
        if (stop) m_run = 0;
        else if (start) m_run = 1;
      end
      rise = pin && !m_pin;
      if (mode != 2'd2 || clr) m_pst = 0;
      else if (rise && m_pst < 2) m_pst = m_pst + 1;
      m_pin = pin;
    end
  end

  function automatic logic [11:0] to_bcd(int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (count !== to_bcd(m_cnt) || irq !== m_irq) begin
        n_bad++;
        $display("FAIL %s: count=%h irq=%b expected count=%h irq=%b",
                 tag, count, irq, to_bcd(m_cnt), m_irq);
      end
    end
  end

  task automatic cyc(input logic t, input logic st = 0, input logic sp = 0,
                     input logic cl = 0);
    tick = t; start = st; stop = sp; clr = cl;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: expired, expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    n_chk++;
    if (count !== 12'h000 || irq !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: count=%h irq=%b expected count=000 irq=0", count, irq);
    end
    rst_n = 1'b1;
    @(negedge clk);

    tag = "R4"; mode = 2'd0;
    ticks(3);                 // run flag low after reset
    cyc(0, 1);
    tag = "R2"; ticks(12);
    tag = "R3"; repeat (5) cyc(0);
    cyc(1); cyc(0); cyc(1);
    tag = "R4"; cyc(1, 0, 1); // stop with tick: that tick still counts
    ticks(4);
    cyc(0, 1, 1);             // both strobes: stop wins
    ticks(4);

    tag = "R5"; mode = 2'd1; pin = 0;
    cyc(0, 1); ticks(2);
    mode = 2'd0; ticks(4);    // still stopped
    cyc(0, 1); mode = 2'd2; cyc(0, 0, 1); mode = 2'd0; ticks(4); // still running

    tag = "R9"; cyc(1, 0, 0, 1); ticks(3); cyc(1, 1, 0, 1); ticks(2);

    tag = "R6"; mode = 2'd1;
    for (int i = 0; i < 24; i++) begin
      pin = (i % 5) < 2;
      cyc(i % 3 != 0);
    end
    pin = 0;

    tag = "R7"; cyc(0, 0, 0, 1); mode = 2'd2;
    ticks(4);
    pin = 1; ticks(6); pin = 0; ticks(7);
    pin = 1; ticks(3); pin = 0; ticks(5);
    pin = 1; ticks(3); pin = 0; ticks(2); // frozen
    cyc(0, 0, 0, 1); ticks(3);
    pin = 1; ticks(2); pin = 0; ticks(3); pin = 1; ticks(2);
    mode = 2'd0; ticks(1); mode = 2'd2; ticks(3); // rearmed by mode exit
    pin = 0; ticks(2); pin = 1; ticks(4); pin = 0; ticks(2);

    tag = "R8"; mode = 2'd3; pin = 1; ticks(6); cyc(0, 1); ticks(3);

    tag = "R10"; pin = 0; mode = 2'd0; sel = 0;
    cyc(0, 0, 0, 1); cyc(0, 1);
    ticks(250);
    tag = "R11"; sel = 1; ticks(820);
    tag = "R2"; sel = 0; ticks(20);

    finish_run();
  end
endmodule